// File: doc/BRIEF.md
# Eight-Pin General-Purpose I/O Port with Peripheral Override

This block is an 8-bit general-purpose I/O port. Software sets each pin's direction and its output or pull-up bit through a small register window. Each pin also computes four pad controls: driver enable, driven level, pull-up enable and digital input enable. Any peripheral that shares the pins can take over each of the four controls separately, one pin at a time. It does this with an enable/value pair per control, and that pair takes precedence over the software registers.

Two input paths come back from the pads. The peripheral receives a raw, unsynchronized copy of the gated pad level. Software reads a copy that has passed through a two-flop synchronizer. A control register carries a global pull-up disable bit and four spare read/write control bits. Digital inputs are gated off in sleep unless a peripheral overrides that gating.

Top module: `gpio_port`

## Requirements
- R1: After reset, the direction, port and control registers all read 0, every pin has padOe=0 and padPullUp=0, and padOut is 0.
- R2: When wrEn is high at a rising clock edge, wrData is written to the register selected by wrAddr: 0 is direction, 1 is port, 3 is control. rdData is a combinational read of the register selected by rdAddr, with 2 selecting the synchronized pin value.
- R3: In the control register, bits 7, 3, 2, 1 and 0 are read/write and bits 6 to 4 always read 0. Bit 2 is the global pull-up disable.
- R4: When a pin's puOvrEn bit is 0, padPullUp is 1 only when its direction bit is 0, its port bit is 1 and control bit 2 is 0.
- R5: When a pin's puOvrEn bit is 1, padPullUp equals puOvrVal for that pin, whatever the direction, port and control bits are.
- R6: padOe equals dirOvrVal where dirOvrEn is 1, and the direction register bit elsewhere.
- R7: Where padOe is 1, padOut equals valOvrVal if valOvrEn is 1, and the port bit otherwise. Where padOe is 0, padOut is 0.
- R8: padInEn equals dinOvrVal where dinOvrEn is 1. Elsewhere it is the inverse of sleepMode.
- R9: altDin equals padIn AND padInEn, combinationally, with no clock delay.
- R10: The pin value read at address 2 is padIn AND padInEn delayed by two rising edges. It reads 0 immediately on any pin whose input is disabled.
- R11: A write to address 2 changes no register.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rstN | input | 1 | Active-low asynchronous reset |
| wrEn | input | 1 | Register write strobe |
| wrAddr | input | 2 | Write register select |
| wrData | input | 8 | Write data |
| rdAddr | input | 2 | Read register select |
| rdData | output | 8 | Read data |
| sleepMode | input | 1 | Device in sleep: digital inputs disabled unless overridden |
| puOvrEn | input | 8 | Per-pin pull-up override enable |
| puOvrVal | input | 8 | Per-pin pull-up override value |
| dirOvrEn | input | 8 | Per-pin driver-enable override enable |
| dirOvrVal | input | 8 | Per-pin driver-enable override value |
| valOvrEn | input | 8 | Per-pin output-value override enable |
| valOvrVal | input | 8 | Per-pin output-value override value |
| dinOvrEn | input | 8 | Per-pin input-enable override enable |
| dinOvrVal | input | 8 | Per-pin input-enable override value |
| padIn | input | 8 | Level seen at each pad |
| padOe | output | 8 | Pad output driver enable |
| padOut | output | 8 | Level driven on each pad |
| padPullUp | output | 8 | Pad pull-up enable |
| padInEn | output | 8 | Pad digital input enable |
| altDin | output | 8 | Raw gated input to peripherals |

## Verification
A wrong direction, port or control bit appears at the pad controls in the same cycle, because those outputs are pure logic on the registers. It also appears on the next read of that register. A fault in the synchronizer shows as a pin value that arrives one edge early, one edge late, or stuck. The bench catches this by sampling between the first and second edge after a pad change. A priority error between an override pair and a register bit only appears when the two disagree, so the random stimulus sets both sides independently. A pull-up fault shows in only one of the eight direction/port/disable combinations, so that combination is also checked directly.

// File: rtl/gpio_pkg.sv
package gpio_pkg;
  localparam int PORT_W   = 8;
  localparam int ADDR_W   = 2;
  localparam int PUD_BIT  = 2;
  localparam logic [PORT_W-1:0] CTRL_RW_MASK = 8'b1000_1111;

  typedef enum logic [ADDR_W-1:0] {
    SEL_DIR  = 2'd0,
    SEL_PORT = 2'd1,
    SEL_PIN  = 2'd2,
    SEL_CTRL = 2'd3
  } regSel_e;

  typedef struct packed {
    logic              wrDir;
    logic              wrPort;
    logic              wrCtrl;
    logic [PORT_W-1:0] data;
    regSel_e           rdSel;
  } gpioStrobe_t;
endpackage

// File: rtl/gpio_ctrl.sv
module gpio_ctrl
  import gpio_pkg::*;
(
  input  logic              clk,
  input  logic              rstN,
  input  logic              wrEn,
  input  logic [ADDR_W-1:0] wrAddr,
  input  logic [PORT_W-1:0] wrData,
  input  logic [ADDR_W-1:0] rdAddr,
  output gpioStrobe_t       stb
);
  regSel_e wrSel;

  always_comb begin
    wrSel      = regSel_e'(wrAddr);
    stb.wrDir  = wrEn && (wrSel == SEL_DIR);
    stb.wrPort = wrEn && (wrSel == SEL_PORT);
    stb.wrCtrl = wrEn && (wrSel == SEL_CTRL);
    stb.data   = wrData;
    stb.rdSel  = regSel_e'(rdAddr);
  end

  // R2
  strobe_onehot_chk: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0({stb.wrDir, stb.wrPort, stb.wrCtrl}));

  // R11
  pin_addr_nowrite_chk: assert property (@(posedge clk) disable iff (!rstN)
    (wrEn && wrAddr == 2'd2) |-> !(stb.wrDir || stb.wrPort || stb.wrCtrl));
endmodule

// File: rtl/gpio_datapath.sv
module gpio_datapath
  import gpio_pkg::*;
#(
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rstN,
  input  gpioStrobe_t       stb,
  input  logic              sleepMode,
  input  logic [PORT_W-1:0] puOvrEn,
  input  logic [PORT_W-1:0] puOvrVal,
  input  logic [PORT_W-1:0] dirOvrEn,
  input  logic [PORT_W-1:0] dirOvrVal,
  input  logic [PORT_W-1:0] valOvrEn,
  input  logic [PORT_W-1:0] valOvrVal,
  input  logic [PORT_W-1:0] dinOvrEn,
  input  logic [PORT_W-1:0] dinOvrVal,
  input  logic [PORT_W-1:0] padIn,
  output logic [PORT_W-1:0] rdData,
  output logic [PORT_W-1:0] padOe,
  output logic [PORT_W-1:0] padOut,
  output logic [PORT_W-1:0] padPullUp,
  output logic [PORT_W-1:0] padInEn,
  output logic [PORT_W-1:0] altDin
);
  localparam int LAST = SYNC_STAGES - 1;

  logic [PORT_W-1:0] dirReg, portReg, ctrlReg;
  logic [PORT_W-1:0] gatedIn, pinRead;
  logic [PORT_W-1:0] syncQ [SYNC_STAGES];
  logic              pullOff;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      dirReg  <= '0;
      portReg <= '0;
      ctrlReg <= '0;
    end else begin
      if (stb.wrDir)  dirReg  <= stb.data;
      if (stb.wrPort) portReg <= stb.data;
      if (stb.wrCtrl) ctrlReg <= stb.data & CTRL_RW_MASK;
    end
  end

  assign pullOff = ctrlReg[PUD_BIT];

  genvar p;
  generate
    for (p = 0; p < PORT_W; p++) begin : g_pin
      always_comb begin
        padOe[p]     = dirOvrEn[p] ? dirOvrVal[p] : dirReg[p];
        padOut[p]    = padOe[p] & (valOvrEn[p] ? valOvrVal[p] : portReg[p]);
        padPullUp[p] = puOvrEn[p] ? puOvrVal[p]
                                  : (!dirReg[p] && portReg[p] && !pullOff);
        padInEn[p]   = dinOvrEn[p] ? dinOvrVal[p] : !sleepMode;
        gatedIn[p]   = padIn[p] & padInEn[p];
      end
    end
  endgenerate

  assign altDin = gatedIn;

  genvar s;
  generate
    for (s = 0; s < SYNC_STAGES; s++) begin : g_sync
      always_ff @(posedge clk or negedge rstN) begin
        if (!rstN)       syncQ[s] <= '0;
        else if (s == 0) syncQ[s] <= gatedIn;
        else             syncQ[s] <= syncQ[(s == 0) ? 0 : s - 1];
      end
    end
  endgenerate

  assign pinRead = syncQ[LAST] & padInEn;

  always_comb begin
    unique case (stb.rdSel)
      SEL_DIR:  rdData = dirReg;
      SEL_PORT: rdData = portReg;
      SEL_PIN:  rdData = pinRead;
      SEL_CTRL: rdData = ctrlReg;
      default:  rdData = '0;
    endcase
  end

  logic [1:0] warm;
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)          warm <= '0;
    else if (warm != 3) warm <= warm + 2'd1;
  end

  // R2
  dir_write_chk: assert property (@(posedge clk) disable iff (!rstN)
    stb.wrDir |=> dirReg == $past(stb.data));

  // R3
  ctrl_reserved_chk: assert property (@(posedge clk) disable iff (!rstN)
    (ctrlReg & ~CTRL_RW_MASK) == '0);

  // R6
  oe_override_chk: assert property (@(posedge clk) disable iff (!rstN)
    ((padOe ^ dirOvrVal) & dirOvrEn) == '0);

  // R7
  idle_drive_chk: assert property (@(posedge clk) disable iff (!rstN)
    (padOut & ~padOe) == '0);

  // R10
  pin_gate_chk: assert property (@(posedge clk) disable iff (!rstN)
    (pinRead & ~padInEn) == '0);

  // R10
  sync_first_chk: assert property (@(posedge clk) disable iff (!rstN)
    (warm != 0) |-> syncQ[0] == $past(gatedIn));

  // R11
  regs_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    !(stb.wrDir || stb.wrPort || stb.wrCtrl) |=> $stable({dirReg, portReg, ctrlReg}));
endmodule

// File: rtl/gpio_port.sv
module gpio_port
  import gpio_pkg::*;
#(
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              wrEn,
  input  logic [ADDR_W-1:0] wrAddr,
  input  logic [PORT_W-1:0] wrData,
  input  logic [ADDR_W-1:0] rdAddr,
  output logic [PORT_W-1:0] rdData,
  input  logic              sleepMode,
  input  logic [PORT_W-1:0] puOvrEn,
  input  logic [PORT_W-1:0] puOvrVal,
  input  logic [PORT_W-1:0] dirOvrEn,
  input  logic [PORT_W-1:0] dirOvrVal,
  input  logic [PORT_W-1:0] valOvrEn,
  input  logic [PORT_W-1:0] valOvrVal,
  input  logic [PORT_W-1:0] dinOvrEn,
  input  logic [PORT_W-1:0] dinOvrVal,
  input  logic [PORT_W-1:0] padIn,
  output logic [PORT_W-1:0] padOe,
  output logic [PORT_W-1:0] padOut,
  output logic [PORT_W-1:0] padPullUp,
  output logic [PORT_W-1:0] padInEn,
  output logic [PORT_W-1:0] altDin
);
  gpioStrobe_t stb;

  gpio_ctrl u_ctrl (
    .clk(clk), .rstN(rstN), .wrEn(wrEn), .wrAddr(wrAddr),
    .wrData(wrData), .rdAddr(rdAddr), .stb(stb)
  );

  gpio_datapath #(.SYNC_STAGES(SYNC_STAGES)) u_dp (
    .clk(clk), .rstN(rstN), .stb(stb), .sleepMode(sleepMode),
    .puOvrEn(puOvrEn), .puOvrVal(puOvrVal),
    .dirOvrEn(dirOvrEn), .dirOvrVal(dirOvrVal),
    .valOvrEn(valOvrEn), .valOvrVal(valOvrVal),
    .dinOvrEn(dinOvrEn), .dinOvrVal(dinOvrVal),
    .padIn(padIn), .rdData(rdData), .padOe(padOe), .padOut(padOut),
    .padPullUp(padPullUp), .padInEn(padInEn), .altDin(altDin)
  );

  // R1
  reset_idle_chk: assert property (@(posedge clk) $rose(rstN) |-> (padOe & ~dirOvrEn) == '0);
endmodule

// File: tb/gpio_port_bench.sv
`timescale 1ns/1ps
module gpio_port_bench;
  logic clk = 0, rstN = 0;
  logic wrEn = 0;
  logic [1:0] wrAddr = 0, rdAddr = 0;
  logic [7:0] wrData = 0, rdData;
  logic sleepMode = 0;
  logic [7:0] puOvrEn = 0, puOvrVal = 0, dirOvrEn = 0, dirOvrVal = 0;
  logic [7:0] valOvrEn = 0, valOvrVal = 0, dinOvrEn = 0, dinOvrVal = 0;
  logic [7:0] padIn = 0;
  logic [7:0] padOe, padOut, padPullUp, padInEn, altDin;

  int checks = 0, errors = 0;
  bit done = 0;
  logic [7:0] mDir = 0, mPort = 0, mCtrl = 0;

  always #2.5 clk = ~clk;

  gpio_port u_gpio_port (.*);

  function automatic logic [7:0] expOe();
    return (dirOvrEn & dirOvrVal) | (~dirOvrEn & mDir);
  endfunction
  function automatic logic [7:0] expOut();
    return expOe() & ((valOvrEn & valOvrVal) | (~valOvrEn & mPort));
  endfunction
  function automatic logic [7:0] expPull();
    logic [7:0] base = ~mDir & mPort & {8{~mCtrl[2]}};
    return (puOvrEn & puOvrVal) | (~puOvrEn & base);
  endfunction
  function automatic logic [7:0] expInEn();
    return (dinOvrEn & dinOvrVal) | (~dinOvrEn & {8{~sleepMode}});
  endfunction

  task automatic chk(string tag, logic [7:0] act, logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic wr(logic [1:0] a, logic [7:0] d);
    @(negedge clk);
    wrEn = 1; wrAddr = a; wrData = d;
    @(negedge clk);
    wrEn = 0;
    if (a == 0) mDir = d;
    else if (a == 1) mPort = d;
    else if (a == 3) mCtrl = d & 8'h8F;
  endtask

  task automatic rd(logic [1:0] a, string tag, logic [7:0] exp);
    rdAddr = a; #0.5;
    chk(tag, rdData, exp);
  endtask

  task automatic chkPads();
    #1;
    chk("R6 padOe", padOe, expOe());
    chk("R7 padOut", padOut, expOut());
    chk("R4/R5 padPullUp", padPullUp, expPull());
    chk("R8 padInEn", padInEn, expInEn());
    chk("R9 altDin", altDin, padIn & expInEn());
  endtask

  task automatic finishRun();
    if (!done) begin
      done = 1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  endtask

  initial begin
    #(200000 * 5);
    errors++;
    $display("FAIL watchdog actual=running expected=finished");
    finishRun();
  end

  initial begin
    void'($urandom(32'h1234_5678));
    repeat (3) @(negedge clk);
    rstN = 1;
    @(negedge clk); #1;
    // R1 reset state
    rd(0, "R1 dir", 8'h00);
    rd(1, "R1 port", 8'h00);
    rd(3, "R1 ctrl", 8'h00);
    chk("R1 padOe", padOe, 8'h00);
    chk("R1 padPullUp", padPullUp, 8'h00);
    chk("R1 padOut", padOut, 8'h00);

    // R2 / R3 register access
    wr(0, 8'h3C); rd(0, "R2 dir", 8'h3C);
    wr(1, 8'hA5); rd(1, "R2 port", 8'hA5);
    wr(3, 8'hFF); rd(3, "R3 ctrl mask", 8'h8F);
    wr(3, 8'h70); rd(3, "R3 ctrl reserved", 8'h00);
    // R11 write to pin address ignored
    wr(2, 8'hFF);
    rd(0, "R11 dir", 8'h3C); rd(1, "R11 port", 8'hA5); rd(3, "R11 ctrl", 8'h00);

    // R4 pull-up truth: dir=0 port=1 pud=0 only
    wr(0, 8'h0F); wr(1, 8'h33);
    chkPads(); chk("R4 pull", padPullUp, 8'h30);
    wr(3, 8'h04);
    chkPads(); chk("R4 pud", padPullUp, 8'h00);
    // R5 override beats disable
    @(negedge clk); puOvrEn = 8'hF0; puOvrVal = 8'h5A;
    chkPads(); chk("R5 pull ovr", padPullUp, 8'h50);
    puOvrEn = 0; puOvrVal = 0;

    // R10 synchronizer latency
    wr(3, 8'h00);
    @(negedge clk); sleepMode = 0; padIn = 8'h00;
    repeat (3) @(negedge clk);
    padIn = 8'hC3;
    @(posedge clk); #1; rd(2, "R10 first edge", 8'h00);
    @(posedge clk); #1; rd(2, "R10 second edge", 8'hC3);
    // R10 disabled reads zero immediately; R8 sleep
    @(negedge clk); sleepMode = 1;
    #1; rd(2, "R10 sleep zero", 8'h00);
    chk("R9 altDin sleep", altDin, 8'h00);
    dinOvrEn = 8'h0F; dinOvrVal = 8'h0F;
    chkPads();
    repeat (2) @(posedge clk); #1; rd(2, "R10 ovr pins", 8'h03);
    dinOvrEn = 0; dinOvrVal = 0; sleepMode = 0;

    // random mix
    for (int i = 0; i < 400; i++) begin
      if (($urandom % 4) == 0) wr(2'($urandom % 4), 8'($urandom));
      @(negedge clk);
      sleepMode = 1'($urandom);
      puOvrEn = 8'($urandom);  puOvrVal = 8'($urandom);
      dirOvrEn = 8'($urandom); dirOvrVal = 8'($urandom);
      valOvrEn = 8'($urandom); valOvrVal = 8'($urandom);
      dinOvrEn = 8'($urandom); dinOvrVal = 8'($urandom);
      padIn = 8'($urandom);
      chkPads();
      repeat (2) @(posedge clk); #1;
      rd(2, "R10 random pin", padIn & expInEn());
      rd(0, "R2 random dir", mDir);
      rd(1, "R2 random port", mPort);
      rd(3, "R3 random ctrl", mCtrl);
    end
    finishRun();
  end
endmodule